// File: doc/BRIEF.md
# Outbound Address Window Translator

This block holds a small bank of programmable windows that map addresses seen on a local bus onto link-side addresses. Each window carries a control word (enable, kind of access, size mask), a local base and a 64-bit remote base. Software programs the windows through a simple word-wide register port. The datapath then presents one local address per cycle for lookup. The block answers one cycle later with the matching window number, its kind and the translated 64-bit address. If no window matches, it raises a miss flag instead.

The size of a window is given as a mask of ones in the upper part of the control word, from bit 10 up. A separate extension register provides the upper 32 bits of the same mask. Memory and I/O windows replace the masked bits of the address with the remote base and keep the offset bits below the mask. Configuration windows place a bus/device/function tag, taken from the remote low word, in bits 31:16 of the result. When windows overlap, the lowest-numbered window takes the lookup.

Top module: `ob_xlate_win`

## Requirements
- R1: After reset every register reads zero and every lookup reports a miss.
- R2: Register map (byte address, bits 1:0 must be zero):
  - Window i uses 0x10*i+0x0 for control, +0x4 for local base, +0x8 for remote low and +0xC for remote high.
  - The size extension of window i is at 0x100+4*i.
  - Reads are combinational.
  - A write changes lookups from the cycle after the write. A lookup in the same cycle as a write sees the old value.
  - Unmapped or misaligned addresses read zero, and writes to them change nothing.
- R3: Control word fields:
  - Bit 0 is enable.
  - Bits 2:1 are the kind: 0 configuration, 1 I/O, 2 memory, 3 reserved.
  - Bits 31:10 are the low part of the size mask.
  - Bits 9:3 always read zero.
- R4: Bits 1:0 of a local base register always read zero.
- R5: Window i hits when all three hold: it is enabled, its kind is not 3, and (addr & M) equals (base & M). M is {ctl[31:10], 10'b0}.
- R6: xl_valid is high exactly in the cycle after a cycle with look_valid high, and the result belongs to that lookup.
- R7: For an I/O or memory hit, xl_addr = (R & K) | ({32'b0, addr} & ~K). R is {remote high, remote low} and K is {extension, ctl[31:10], 10'b0}.
- R8: For a configuration hit, xl_addr is built from three parts, high to low:
  - remote high;
  - remote low bits 31:16, which hold the bus number in 31:24, the device number in 23:19 and the function number in 18:16;
  - addr[15:0] & ~K[15:0].
- R9: When several windows hit, the lowest-numbered one is reported on xl_win, xl_type and xl_addr.
- R10: On a miss, xl_miss is 1 and xl_win, xl_type and xl_addr are all zero.
- R11: A window whose kind is 3 never hits, even when enabled and matching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 9 | Register byte address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational) |
| look_valid | input | 1 | Lookup request |
| look_addr | input | 32 | Local address to translate |
| xl_valid | output | 1 | Result valid, one cycle after a request |
| xl_miss | output | 1 | No window matched |
| xl_win | output | $clog2(NWIN) (3) | Winning window index |
| xl_type | output | 2 | Kind of the winning window |
| xl_addr | output | 64 | Translated address |

## Verification
Lookups are tried against three kinds of window: a configuration window, whose result must carry the bus/device/function tag, and memory and I/O windows, whose results must mix base and offset bits at the mask edge. Overlapping windows are then enabled and disabled in turn, which separates the priority rule from plain matching. A reserved-kind window placed over an address shows that it is excluded, and an extension mask with zero bits shows that the upper mask half is used. A long random phase follows, with register writes landing in the same cycle as lookups. A behavioural model checks every cycle, which catches stale or early register use.

// File: rtl/ob_xlate_win.sv
module ob_xlate_win #(
  parameter int NWIN = 8
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                cfg_we,
  input  logic [8:0]                          cfg_addr,
  input  logic [31:0]                         cfg_wdata,
  output logic [31:0]                         cfg_rdata,
  input  logic                                look_valid,
  input  logic [31:0]                         look_addr,
  output logic                                xl_valid,
  output logic                                xl_miss,
  output logic [((NWIN > 1) ? $clog2(NWIN) : 1)-1:0] xl_win,
  output logic [1:0]                          xl_type,
  output logic [63:0]                         xl_addr
);
  localparam int WW = (NWIN > 1) ? $clog2(NWIN) : 1;
  localparam logic [1:0] T_CFG = 2'd0;
  localparam logic [1:0] T_RSV = 2'd3;
  localparam logic [31:0] CTL_KEEP = 32'hFFFF_FC07;

  logic [31:0] ctl_q   [NWIN];
  logic [31:0] lbase_q [NWIN];
  logic [31:0] rlo_q   [NWIN];
  logic [31:0] rhi_q   [NWIN];
  logic [31:0] ext_q   [NWIN];

  logic [3:0] widx;
  logic [5:0] eidx;
  logic       in_win, in_ext;

  assign widx   = cfg_addr[7:4];
  assign eidx   = cfg_addr[7:2];
  assign in_win = !cfg_addr[8] && cfg_addr[1:0] == 2'b00 && int'(widx) < NWIN;
  assign in_ext =  cfg_addr[8] && cfg_addr[1:0] == 2'b00 && int'(eidx) < NWIN;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NWIN; i++) begin
        ctl_q[i]   <= '0;
        lbase_q[i] <= '0;
        rlo_q[i]   <= '0;
        rhi_q[i]   <= '0;
        ext_q[i]   <= '0;
      end
    end else if (cfg_we) begin
      for (int i = 0; i < NWIN; i++) begin
        if (in_win && int'(widx) == i) begin
          case (cfg_addr[3:2])
            2'd0:    ctl_q[i]   <= cfg_wdata & CTL_KEEP;
            2'd1:    lbase_q[i] <= {cfg_wdata[31:2], 2'b00};
            2'd2:    rlo_q[i]   <= cfg_wdata;
            default: rhi_q[i]   <= cfg_wdata;
          endcase
        end
        if (in_ext && int'(eidx) == i) ext_q[i] <= cfg_wdata;
      end
    end
  end

  always_comb begin
    cfg_rdata = '0;
    for (int i = 0; i < NWIN; i++) begin
      if (in_win && int'(widx) == i) begin
        case (cfg_addr[3:2])
          2'd0:    cfg_rdata = ctl_q[i];
          2'd1:    cfg_rdata = lbase_q[i];
          2'd2:    cfg_rdata = rlo_q[i];
          default: cfg_rdata = rhi_q[i];
        endcase
      end
      if (in_ext && int'(eidx) == i) cfg_rdata = ext_q[i];
    end
  end

  logic [NWIN-1:0] hit, en_vec;
  logic [63:0]     xa [NWIN];

  for (genvar g = 0; g < NWIN; g++) begin : g_win
    logic [63:0] msk;
    logic [1:0]  kind;
    assign kind      = ctl_q[g][2:1];
    assign msk       = {ext_q[g], ctl_q[g][31:10], 10'b0};
    assign en_vec[g] = ctl_q[g][0];
    assign hit[g]    = en_vec[g] && kind != T_RSV &&
                       ((look_addr & msk[31:0]) == (lbase_q[g] & msk[31:0]));
    assign xa[g]     = (kind == T_CFG)
                     ? {rhi_q[g], rlo_q[g][31:16], look_addr[15:0] & ~msk[15:0]}
                     : (({rhi_q[g], rlo_q[g]} & msk) | ({32'b0, look_addr} & ~msk));
  end

  logic          sel_hit;
  logic [WW-1:0] sel_w;
  logic [63:0]   sel_a;
  logic [1:0]    sel_t;

  always_comb begin
    sel_hit = 1'b0;
    sel_w   = '0;
    sel_a   = '0;
    sel_t   = '0;
    for (int i = NWIN - 1; i >= 0; i--) begin
      if (hit[i]) begin
        sel_hit = 1'b1;
        sel_w   = WW'(i);
        sel_a   = xa[i];
        sel_t   = ctl_q[i][2:1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xl_valid <= 1'b0;
      xl_miss  <= 1'b0;
      xl_win   <= '0;
      xl_type  <= '0;
      xl_addr  <= '0;
    end else begin
      xl_valid <= look_valid;
      xl_miss  <= look_valid && !sel_hit;
      xl_win   <= (look_valid && sel_hit) ? sel_w : '0;
      xl_type  <= (look_valid && sel_hit) ? sel_t : '0;
      xl_addr  <= (look_valid && sel_hit) ? sel_a : '0;
    end
  end

  // R6
  valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    look_valid |=> xl_valid);
  // R6
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !look_valid |=> !xl_valid);
  // R10
  miss_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xl_miss |-> (xl_valid && xl_addr == 64'd0 && xl_win == '0 && xl_type == 2'd0));
  // R11
  no_rsv_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xl_valid && !xl_miss) |-> xl_type != T_RSV);
  // R5
  hit_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xl_valid && !xl_miss) |-> |($past(en_vec) & (NWIN'(1) << xl_win)));
  // R4
  base_lsb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_addr[8] && cfg_addr[3:2] == 2'd1) |-> cfg_rdata[1:0] == 2'b00);
endmodule

// File: tb/ob_xlate_win_test.sv
module ob_xlate_win_test;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [8:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        look_valid = 1'b0;
  logic [31:0] look_addr = '0;
  logic        xl_valid, xl_miss;
  logic [2:0]  xl_win;
  logic [1:0]  xl_type;
  logic [63:0] xl_addr;

  int total = 0;
  int fails = 0;
  bit running = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  ob_xlate_win #(.NWIN(8)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .look_valid(look_valid),
    .look_addr(look_addr), .xl_valid(xl_valid), .xl_miss(xl_miss),
    .xl_win(xl_win), .xl_type(xl_type), .xl_addr(xl_addr)
  );

  logic [31:0] m_ctl [8], m_base [8], m_lo [8], m_hi [8], m_ext [8];
  logic        e_valid, e_miss;
  logic [2:0]  e_win;
  logic [1:0]  e_type;
  logic [63:0] e_addr;
  string       e_tm, e_tw, e_ta;
  logic [63:0] mk;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] mread(input logic [8:0] a);
    if (a[1:0] != 2'b00) return 32'd0;
    if (!a[8] && a[7:4] < 8) begin
      case (a[3:2])
        2'd0: return m_ctl[a[6:4]];
        2'd1: return m_base[a[6:4]];
        2'd2: return m_lo[a[6:4]];
        default: return m_hi[a[6:4]];
      endcase
    end
    if (a[8] && a[7:2] < 8) return m_ext[a[4:2]];
    return 32'd0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) begin
        m_ctl[i] = 0; m_base[i] = 0; m_lo[i] = 0; m_hi[i] = 0; m_ext[i] = 0;
      end
      e_valid = 0; e_miss = 0; e_win = 0; e_type = 0; e_addr = 0;
      e_tm = "R1"; e_tw = "R1"; e_ta = "R1";
    end else begin
      int nh;
      int w;
      bit rsv;
      nh = 0; w = 0; rsv = 0;
      for (int i = 0; i < 8; i++) begin
        mk = {m_ext[i], m_ctl[i][31:10], 10'b0};
        if (m_ctl[i][0] && ((look_addr & mk[31:0]) == (m_base[i] & mk[31:0]))) begin
          if (m_ctl[i][2:1] == 2'd3) rsv = 1;
          else begin
            if (nh == 0) w = i;
            nh++;
          end
        end
      end
      e_valid = look_valid;
      e_miss = look_valid && nh == 0;
      e_tm = (nh > 0) ? "R5" : (rsv ? "R11" : "R10");
      e_tw = (nh > 1) ? "R9" : "R5";
      if (look_valid && nh > 0) begin
        mk = {m_ext[w], m_ctl[w][31:10], 10'b0};
        e_win = 3'(w);
        e_type = m_ctl[w][2:1];
        if (m_ctl[w][2:1] == 2'd0) begin
          e_addr = {m_hi[w], m_lo[w][31:16], look_addr[15:0] & ~mk[15:0]};
          e_ta = "R8";
        end else begin
          e_addr = ({m_hi[w], m_lo[w]} & mk) | ({32'b0, look_addr} & ~mk);
          e_ta = "R7";
        end
      end else begin
        e_win = 0; e_type = 0; e_addr = 0; e_ta = "R10";
      end
      if (cfg_we && cfg_addr[1:0] == 2'b00) begin
        if (!cfg_addr[8] && cfg_addr[7:4] < 8) begin
          case (cfg_addr[3:2])
            2'd0: m_ctl[cfg_addr[6:4]] = cfg_wdata & 32'hFFFF_FC07;
            2'd1: m_base[cfg_addr[6:4]] = cfg_wdata & 32'hFFFF_FFFC;
            2'd2: m_lo[cfg_addr[6:4]] = cfg_wdata;
            default: m_hi[cfg_addr[6:4]] = cfg_wdata;
          endcase
        end else if (cfg_addr[8] && cfg_addr[7:2] < 8) m_ext[cfg_addr[4:2]] = cfg_wdata;
      end
    end
  end

  always @(negedge clk) begin
    if (running) begin
      chk(xl_valid === e_valid, "R6", 64'(xl_valid), 64'(e_valid));
      chk(xl_miss === e_miss, e_tm, 64'(xl_miss), 64'(e_miss));
      chk(xl_win === e_win, e_tw, 64'(xl_win), 64'(e_win));
      chk(xl_type === e_type, e_tw, 64'(xl_type), 64'(e_type));
      chk(xl_addr === e_addr, e_ta, xl_addr, e_addr);
    end
  end

  task automatic step(input bit we, input logic [8:0] a, input logic [31:0] d,
                      input bit lv, input logic [31:0] la);
    @(negedge clk);
    cfg_we = we; cfg_addr = a; cfg_wdata = d; look_valid = lv; look_addr = la;
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    step(1, a, d, 0, 0);
  endtask

  task automatic lk(input logic [31:0] la);
    step(0, 0, 0, 1, la);
  endtask

  task automatic rd(input logic [8:0] a, input string tag);
    step(0, a, 0, 0, 0);
    #1;
    chk(cfg_rdata === mread(a), tag, 64'(cfg_rdata), 64'(mread(a)));
  endtask

  initial begin
    #(CLK_P * 150000);
    total++; fails++;
    $display("FAIL R6 watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    running = 1'b1;
    // R1: reset state
    for (int i = 0; i < 8; i++) begin
      rd(9'(16 * i), "R1"); rd(9'(16 * i + 4), "R1");
      rd(9'(16 * i + 8), "R1"); rd(9'(16 * i + 12), "R1");
      rd(9'(256 + 4 * i), "R1");
    end
    lk(32'h0000_0000); lk(32'hFFFF_FFFF);
    // R3 R8: config window with stray control bits
    wr(9'h000, 32'hFFFF_F3F9); wr(9'h004, 32'h4000_0003);
    wr(9'h008, 32'h032A_0000); wr(9'h00C, 32'h0000_0001);
    wr(9'h100, 32'hFFFF_FFFF);
    rd(9'h000, "R3"); rd(9'h004, "R4");
    lk(32'h4000_0ABC); lk(32'h4000_1ABC);
    // R7: memory window
    wr(9'h010, 32'hF000_0005); wr(9'h014, 32'h8000_0000);
    wr(9'h018, 32'h3000_0000); wr(9'h01C, 32'h0000_0012);
    wr(9'h104, 32'hFFFF_FFFF);
    lk(32'h8123_4567);
    // R9: overlapping I/O window
    wr(9'h020, 32'hFF00_0003); wr(9'h024, 32'h8100_0000);
    wr(9'h028, 32'h5500_0000); wr(9'h108, 32'hFFFF_FFFF);
    lk(32'h8100_0010);
    wr(9'h010, 32'hF000_0004);
    lk(32'h8100_0010);
    // R11: reserved kind
    wr(9'h030, 32'hF000_0007); wr(9'h034, 32'h9000_0000);
    lk(32'h9000_0040);
    // R7: extension mask with zero bits
    wr(9'h040, 32'hFFFF_0005); wr(9'h044, 32'hA000_0000);
    wr(9'h048, 32'h1234_5678); wr(9'h04C, 32'hABCD_1234);
    wr(9'h110, 32'hFFFF_0000);
    lk(32'hA000_BEEF);
    // R2: unmapped, misaligned, same-cycle write
    wr(9'h1F0, 32'hDEAD_BEEF); rd(9'h1F0, "R2");
    wr(9'h0A0, 32'hDEAD_BEEF); rd(9'h0A0, "R2");
    wr(9'h001, 32'h0000_0000); rd(9'h000, "R2");
    step(1, 9'h000, 32'h0000_0000, 1, 32'h4000_0010);
    lk(32'h4000_0010);
    wr(9'h000, 32'hFFFF_F001);
    for (int i = 0; i < 8; i++) rd(9'(16 * i), "R2");
    // random mix
    for (int n = 0; n < 600; n++) begin
      logic [31:0] r;
      r = $urandom;
      if (r[3:0] == 0)
        step(1, 9'({r[6:4], 4'h0}), {r[31:28], 18'h3FFFF, 7'h0, r[9:7]}, r[10], {r[30:28], 29'h0});
      else
        step(0, 0, 0, r[11] | r[12], {r[31:28], 4'h0, r[23:0]});
    end
    step(0, 0, 0, 0, 0);
    @(negedge clk);
    running = 1'b0;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule